// File: doc/BRIEF.md
# Multiplexed-Return Key Matrix Scanner

This block scans a keyboard of 16 strobe lines by 8 matrix returns while using only a 4-bit binary strobe bus and four shared return inputs. An external 4-to-16 decoder turns the strobe code into a one-hot strobe line. An external multiplexer places either the A half or the B half of the eight returns onto the four shared inputs, as chosen by two group-select outputs. Two more return inputs are wired straight in. One carries a mode switch. The other carries the clerk, paper-feed and receipt on/off switches. Both are read on every strobe, so they give 16 more key positions each.

Each strobe slot has two sampling phases of `PHASE_CYC` clocks. Group A is selected in the first phase and group B in the second. Each group is sampled in the last clock of its phase, once the external multiplexer has settled. The block then compares the slot's ten return bits with what it sampled on the previous scan and with the debounced key state. Each confirmed change is emitted as a key code with a press/release flag over a valid/ready handshake. Scanning stops while an event waits to be accepted.

Top module: `keymux_scanner`

## Requirements
- R1: After reset, strobe_code is 0, grp_sel is 2'b01 and evt_valid is 0.
- R2: While scanning, strobe_code is held for two phases of PHASE_CYC clocks each, plus the emit cycles of the slot. It then advances by one, wrapping from 15 to 0.
- R3: grp_sel is 2'b01 in the first phase of a slot and 2'b10 in the second. It is 2'b00 while the slot's changes are emitted, and it never takes the value 2'b11.
- R4: A return input reads 1 when its key is pressed. ret_in[i] is sampled in the last clock of the 2'b01 phase as matrix return i, and in the last clock of the 2'b10 phase as matrix return 4+i.
- R5: A matrix key at strobe s and return r (0..7) reports evt_code = 8*s + r. Returns 0 to 3 belong to group A and returns 4 to 7 to group B.
- R6: The mode return at strobe s reports evt_code = 128 + s. The switch-group return at strobe s reports evt_code = 144 + s.
- R7: A key change is reported only after the new state has been sampled on two consecutive scans. A state seen on one scan only produces no event.
- R8: evt_press is 1 for a press and 0 for a release. Each confirmed change yields exactly one accepted event.
- R9: Several changes confirmed in one slot are emitted one per handshake, lowest return index first, in the order returns 0..7, then mode, then the switch group.
- R10: While evt_valid is high and evt_ready is low, evt_valid, evt_code, evt_press and strobe_code hold steady and grp_sel is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_code | output | 4 | Binary index of the active strobe |
| grp_sel | output | 2 | Return group select: 01 for A, 10 for B, 00 for none |
| ret_in | input | 4 | Shared return inputs from the external multiplexer |
| mode_ret | input | 1 | Dedicated mode-switch return |
| aux_ret | input | 1 | Dedicated return for the clerk, paper-feed and receipt switches |
| evt_valid | output | 1 | A key event is offered |
| evt_ready | input | 1 | The consumer accepts the event |
| evt_code | output | 8 | Key code of the event |
| evt_press | output | 1 | 1 for a press, 0 for a release |

## Verification
The assertions check on every cycle that the group select stays legal and moves only from A to B, that the strobe index only steps by one, that emitted codes stay below 160, and that an event stalled by the consumer keeps its code, flag and strobe. The debounce rule, the mapping of each return to its key code, the emit order inside a slot and the rejection of one-scan glitches depend on key patterns applied over several scans. Only the bench's scenarios and its per-clock reference model can show those.

// File: rtl/keymux_scanner.sv
module keymux_scanner #(
  parameter int PHASE_CYC = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] strobe_code,
  output logic [1:0] grp_sel,
  input  logic [3:0] ret_in,
  input  logic       mode_ret,
  input  logic       aux_ret,
  output logic       evt_valid,
  input  logic       evt_ready,
  output logic [7:0] evt_code,
  output logic       evt_press
);
  localparam int NSTB = 16;
  localparam int NRET = 10;
  localparam int CW   = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

  logic [3:0]      stb_q;
  logic            phase_q, emit_q;
  logic [CW-1:0]   cnt_q;
  logic [3:0]      samp_a_q;
  logic [NRET-1:0] raw_q;
  logic [NRET-1:0] prev_q [NSTB];
  logic [NRET-1:0] stab_q [NSTB];
  logic [NRET-1:0] pend;
  logic [3:0]      idx;

  assign pend = (raw_q ~^ prev_q[stb_q]) & (raw_q ^ stab_q[stb_q]);

  always_comb begin
    idx = 4'd0;
    for (int i = NRET - 1; i >= 0; i--)
      if (pend[i]) idx = 4'(i);
  end

  assign strobe_code = stb_q;
  assign grp_sel     = emit_q ? 2'b00 : (phase_q ? 2'b10 : 2'b01);
  assign evt_valid   = emit_q & (|pend);
  assign evt_press   = raw_q[idx];
  assign evt_code    = (idx < 4'd8) ? {1'b0, stb_q, idx[2:0]} :
                       (idx == 4'd8) ? {4'b1000, stb_q} : {4'b1001, stb_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q    <= '0;
      phase_q  <= 1'b0;
      emit_q   <= 1'b0;
      cnt_q    <= '0;
      samp_a_q <= '0;
      raw_q    <= '0;
      for (int s = 0; s < NSTB; s++) begin
        prev_q[s] <= '0;
        stab_q[s] <= '0;
      end
    end else if (emit_q) begin
      if (!(|pend)) begin
        prev_q[stb_q] <= raw_q;
        stb_q         <= stb_q + 4'd1;
        emit_q        <= 1'b0;
      end else if (evt_ready) begin
        stab_q[stb_q][idx] <= raw_q[idx];
      end
    end else if (cnt_q == CW'(PHASE_CYC - 1)) begin
      cnt_q <= '0;
      if (!phase_q) begin
        samp_a_q <= ret_in;
        phase_q  <= 1'b1;
      end else begin
        raw_q   <= {aux_ret, mode_ret, ret_in, samp_a_q};
        phase_q <= 1'b0;
        emit_q  <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

module keymux_scanner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] strobe_code,
  input logic [1:0] grp_sel,
  input logic       evt_valid,
  input logic       evt_ready,
  input logic [7:0] evt_code,
  input logic       evt_press
);
  p_grp_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grp_sel != 2'b11);

  p_grp_a_to_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_sel == 2'b01) |=> (grp_sel == 2'b01 || grp_sel == 2'b10));

  p_strobe_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(strobe_code) |-> (strobe_code == $past(strobe_code) + 4'd1));

  p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_code < 8'd160));

  p_hold_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_code) && $stable(evt_press)));

  p_stall_scan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> ($stable(strobe_code) && grp_sel == 2'b00));
endmodule

bind keymux_scanner keymux_scanner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_code(strobe_code), .grp_sel(grp_sel),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_code(evt_code),
  .evt_press(evt_press)
);

// File: tb/tb_keymux_scanner.sv
`timescale 1ns/1ps
module tb_keymux_scanner;
  localparam int P = 4;
  localparam int SCAN = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] strobe_code;
  logic [1:0] grp_sel;
  logic [3:0] ret_in;
  logic mode_ret, aux_ret;
  logic evt_valid, evt_ready, evt_press;
  logic [7:0] evt_code;
  logic [159:0] keys = '0;

  int checks = 0, failures = 0;
  int evq[$];

  always #2 clk = ~clk;

  keymux_scanner #(.PHASE_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .strobe_code(strobe_code), .grp_sel(grp_sel),
    .ret_in(ret_in), .mode_ret(mode_ret), .aux_ret(aux_ret),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_code(evt_code),
    .evt_press(evt_press)
  );

  // external decoder + multiplexer model
  always_comb begin
    int s;
    s = int'(strobe_code);
    for (int i = 0; i < 4; i++)
      ret_in[i] = (grp_sel == 2'b01) ? keys[s*8+i] :
                  (grp_sel == 2'b10) ? keys[s*8+4+i] : 1'b0;
    mode_ret = keys[128+s];
    aux_ret  = keys[144+s];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_s, m_cnt;
  bit m_phase, m_emit;
  bit m_sa[4];
  bit m_raw[10];
  bit m_prev[16][10];
  bit m_stab[16][10];

  function automatic int m_first();
    for (int j = 0; j < 10; j++)
      if (m_raw[j] == m_prev[m_s][j] && m_raw[j] != m_stab[m_s][j]) return j;
    return -1;
  endfunction

  always @(negedge clk) begin
    int j, exp_v, act_v, code;
    if (!rst_n) begin
      m_s = 0; m_cnt = 0; m_phase = 0; m_emit = 0;
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 10; b++) begin m_prev[a][b] = 0; m_stab[a][b] = 0; end
      for (int b = 0; b < 10; b++) m_raw[b] = 0;
    end else begin
      j = m_emit ? m_first() : -1;
      code = (j < 0) ? 0 : (j < 8) ? m_s*8 + j : (j == 8) ? 128 + m_s : 144 + m_s;
      exp_v = (m_s << 3) | ((m_emit ? 0 : (m_phase ? 2 : 1)) << 1);
      act_v = (int'(strobe_code) << 3) | (int'(grp_sel) << 1);
      if (j >= 0) begin
        exp_v = exp_v | 1 | (code << 8) | (int'(m_raw[j]) << 16);
        act_v = act_v | int'(evt_valid) | (int'(evt_code) << 8) | (int'(evt_press) << 16);
      end else act_v = act_v | int'(evt_valid);
      chk(act_v == exp_v, "R2/R3/R10 per-clock model", act_v, exp_v);
      if (evt_valid && evt_ready) evq.push_back(int'(evt_press)*256 + int'(evt_code));
      if (m_emit) begin
        if (j < 0) begin
          for (int b = 0; b < 10; b++) m_prev[m_s][b] = m_raw[b];
          m_s = (m_s + 1) % 16; m_emit = 0;
        end else if (evt_ready) m_stab[m_s][j] = m_raw[j];
      end else if (m_cnt == P-1) begin
        m_cnt = 0;
        if (!m_phase) begin
          for (int i = 0; i < 4; i++) m_sa[i] = keys[m_s*8+i];
          m_phase = 1;
        end else begin
          for (int i = 0; i < 4; i++) begin m_raw[i] = m_sa[i]; m_raw[4+i] = keys[m_s*8+4+i]; end
          m_raw[8] = keys[128+m_s]; m_raw[9] = keys[144+m_s];
          m_phase = 0; m_emit = 1;
        end
      end else m_cnt++;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic wait_scans(input int n); repeat (n*SCAN) step(); endtask
  task automatic sync0();
    while (!(strobe_code == 4'd0 && grp_sel == 2'b01)) step();
  endtask
  task automatic set_key(input int k, input bit v); sync0(); keys[k] = v; endtask

  task automatic expect_events(input string tag, input int e0, input int e1, input int e2, input int n);
    int exp[3];
    exp[0] = e0; exp[1] = e1; exp[2] = e2;
    chk(evq.size() == n, {tag, " event count"}, evq.size(), n);
    for (int i = 0; i < n; i++)
      if (i < evq.size()) chk(evq[i] == exp[i], {tag, " event"}, evq[i], exp[i]);
    evq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s0;
    evt_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(strobe_code == 4'd0, "R1 reset strobe", strobe_code, 0);
    chk(grp_sel == 2'b01, "R1 reset grp_sel", grp_sel, 1);
    chk(evt_valid == 1'b0, "R1 reset valid", evt_valid, 0);
    wait_scans(2);
    expect_events("R7 idle no events", 0, 0, 0, 0);

    // R5 R4 R8: group B key, strobe 4 return 5 -> 37
    set_key(37, 1); wait_scans(3);
    expect_events("R5 press code 37", 256+37, 0, 0, 1);
    set_key(37, 0); wait_scans(3);
    expect_events("R8 release code 37", 37, 0, 0, 1);

    // R4 group A key, strobe 9 return 2 -> 74
    set_key(74, 1); wait_scans(3);
    expect_events("R4 group A code 74", 256+74, 0, 0, 1);
    set_key(74, 0); wait_scans(3); evq.delete();

    // R6 dedicated returns
    set_key(128+3, 1); wait_scans(3);
    expect_events("R6 mode strobe 3", 256+131, 0, 0, 1);
    set_key(144+7, 1); wait_scans(3);
    expect_events("R6 switch group strobe 7", 256+151, 0, 0, 1);
    set_key(128+3, 0); keys[144+7] = 0; wait_scans(3); evq.delete();

    // R7 one-scan glitch on key 3 (strobe 0)
    while (strobe_code != 4'd1) step();
    keys[3] = 1;
    while (strobe_code != 4'd0) step();
    while (strobe_code != 4'd1) step();
    keys[3] = 0;
    wait_scans(3);
    expect_events("R7 glitch rejected", 0, 0, 0, 0);

    // R9 three changes in strobe 10
    sync0(); keys[80] = 1; keys[87] = 1; keys[128+10] = 1;
    wait_scans(3);
    expect_events("R9 order in slot", 256+80, 256+87, 256+138, 3);
    sync0(); keys[80] = 0; keys[87] = 0; keys[128+10] = 0;
    wait_scans(3);
    expect_events("R9 release order", 80, 87, 138, 3);

    // R10 back-pressure on key 50 (strobe 6 return 2)
    evt_ready = 1'b0;
    set_key(50, 1);
    while (!evt_valid) step();
    s0 = int'(strobe_code);
    repeat (20) step();
    chk(evt_valid == 1'b1, "R10 valid held", evt_valid, 1);
    chk(int'(strobe_code) == s0, "R10 strobe frozen", strobe_code, s0);
    chk(evt_code == 8'd50, "R10 code held", evt_code, 50);
    chk(grp_sel == 2'b00, "R10 grp idle", grp_sel, 0);
    evt_ready = 1'b1;
    step(); step();
    expect_events("R10 accepted once", 256+50, 0, 0, 1);
    set_key(50, 0); wait_scans(3); evq.delete();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule